// File: doc/BRIEF.md
# Event Flag Register with Interrupt Line Fan-out

This block collects event pulses from a network controller datapath into a 32-bit word of sticky flags. A second 32-bit word holds an enable mask. The flags ANDed with the mask form the active vector. Thirteen of the active bits each drive one dedicated interrupt output line. The link from line to bit is a fixed table, and it is not in bit order.

Software reaches both words over a simple single-cycle register bus. A write to the flag word clears every bit written as one and leaves the other bits alone. A write to the mask word replaces the whole mask. The interrupt lines are registered. A line moves only when the active state of its own source bit differs from the value held for it, so each line follows its source one cycle later.

Top module: `event_irq_fanout`

## Requirements
- R1: While `rst_n` is low, the flag word, the mask word and all thirteen lines are zero. This holds also when reset is applied in the middle of operation.
- R2: A one on `evt_set[b]` at a clock edge sets flag bit b. The bit stays set until software clears it.
- R3: A write to offset 0x004 clears each flag bit whose `wr_data` bit is 1. Flag bits whose `wr_data` bit is 0 keep their value.
- R4: A write to offset 0x008 loads all 32 bits of `wr_data` into the mask word.
- R5: With `rd_addr` at 0x004 or 0x008, `rd_data` returns the flag word or the mask word in the same cycle. Any other offset reads 0. A write to any other offset changes neither word.
- R6: Each line carries flag AND mask of one source bit. Line 0 takes bit 27, line 1 bit 26, line 2 bit 19, line 3 bit 20, line 4 bit 25, line 5 bit 24, line 6 bit 23, line 7 bit 21, line 8 bit 31, line 9 bit 28, line 10 bit 22, line 11 bit 29, line 12 bit 30. Lines are active high.
- R7: After the clock edge that changes the flag word or the mask word, a line takes its new value at the next clock edge, and not before.
- R8: If `evt_set[b]` is high in the same cycle as a clearing write with bit b at 1, flag bit b ends set.
- R9: Flag and mask bits 0 to 18 latch and read back like the others, but they drive no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 10 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 10 | Byte offset of the read |
| rd_data | output | 32 | Read data, combinational |
| evt_set | input | 32 | Event pulses, one per flag bit |
| irq_line | output | 13 | Registered interrupt lines |

## Verification
A corrupted flag or mask bit shows in `rd_data` in the cycle after the faulty edge. It shows on the mapped line one edge later. A wrong entry in the line table sends a source bit to the wrong line. The vectors catch this because they activate single bits and irregular groups of bits under differing masks. A missing output register or an early update is caught by sampling each line both before and after the extra edge that follows a mask write.

// File: rtl/evirq_pkg.sv
package evirq_pkg;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned NUM_LINES = 13;
    localparam int unsigned ADDR_W    = 10;

    // Source bit positions of the named events
    localparam int unsigned B_HBEAT   = 31;
    localparam int unsigned B_RXBAB   = 30;
    localparam int unsigned B_TXBAB   = 29;
    localparam int unsigned B_STOPPED = 28;
    localparam int unsigned B_TXFRM   = 27;
    localparam int unsigned B_TXBUF   = 26;
    localparam int unsigned B_RXFRM   = 25;
    localparam int unsigned B_RXBUF   = 24;
    localparam int unsigned B_MGMT    = 23;
    localparam int unsigned B_BUSERR  = 22;
    localparam int unsigned B_LATECOL = 21;
    localparam int unsigned B_RETRY   = 20;
    localparam int unsigned B_UNDER   = 19;

    // Fixed line -> source bit table
    function automatic int unsigned line_src(input int unsigned line);
        case (line)
            0:       return B_TXFRM;
            1:       return B_TXBUF;
            2:       return B_UNDER;
            3:       return B_RETRY;
            4:       return B_RXFRM;
            5:       return B_RXBUF;
            6:       return B_MGMT;
            7:       return B_LATECOL;
            8:       return B_HBEAT;
            9:       return B_STOPPED;
            10:      return B_BUSERR;
            11:      return B_TXBAB;
            default: return B_RXBAB;
        endcase
    endfunction

    typedef struct packed {
        logic [WORD_W-1:0] flags;
        logic [WORD_W-1:0] mask;
    } evreg_t;
endpackage

// File: rtl/evirq_regs.sv
module evirq_regs #(
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned ADDR_W   = 10,
    parameter int unsigned FLAG_OFS = 'h004,
    parameter int unsigned MASK_OFS = 'h008
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [WORD_W-1:0] evt_set,
    output logic [WORD_W-1:0] flags_q,
    output logic [WORD_W-1:0] mask_q
);
    localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_OFS);
    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_OFS);

    typedef struct packed {
        logic [WORD_W-1:0] flags;
        logic [WORD_W-1:0] mask;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        logic [WORD_W-1:0] clr;
        st_d = st_q;
        clr  = (wr_en && wr_addr == FLAG_A) ? wr_data : '0;
        // set has priority over clear on the same bit
        st_d.flags = (st_q.flags & ~clr) | evt_set;
        if (wr_en && wr_addr == MASK_A) begin
            st_d.mask = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_q = st_q.flags;
    assign mask_q  = st_q.mask;

    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == FLAG_A) |=>
            ((flags_q & $past(wr_data) & ~$past(evt_set)) == '0));

    assert_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == FLAG_A) |=>
            ((flags_q & ~$past(wr_data)) == ($past(flags_q) & ~$past(wr_data))
             | ($past(evt_set) & ~$past(wr_data))));

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set != '0) |=> ((flags_q & $past(evt_set)) == $past(evt_set)));

    assert_mask_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == MASK_A) |=> (mask_q == $past(wr_data)));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && evt_set == '0) |=> ($stable(flags_q) && $stable(mask_q)));
endmodule

// File: rtl/evirq_lines.sv
module evirq_lines #(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned NUM_LINES = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WORD_W-1:0]    active,
    output logic [NUM_LINES-1:0] irq_q
);
    typedef struct packed {
        logic [NUM_LINES-1:0] line;
    } lstate_t;

    lstate_t ls_d, ls_q;
    logic [NUM_LINES-1:0] mapped;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_map
        localparam int unsigned SRC = evirq_pkg::line_src(i);
        assign mapped[i] = active[SRC];

        assert_line_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (irq_q[i] == $past(active[SRC])));
    end

    always_comb begin
        ls_d = ls_q;
        for (int i = 0; i < NUM_LINES; i++) begin
            // a line moves only when its own active bit differs
            if (mapped[i] != ls_q.line[i]) begin
                ls_d.line[i] = mapped[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ls_q <= '0;
        end else begin
            ls_q <= ls_d;
        end
    end

    assign irq_q = ls_q.line;

    assert_line_lag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(active) |=> $stable(irq_q));
endmodule

// File: rtl/event_irq_fanout.sv
module event_irq_fanout #(
    parameter int unsigned WORD_W    = evirq_pkg::WORD_W,
    parameter int unsigned ADDR_W    = evirq_pkg::ADDR_W,
    parameter int unsigned NUM_LINES = evirq_pkg::NUM_LINES,
    parameter int unsigned FLAG_OFS  = 'h004,
    parameter int unsigned MASK_OFS  = 'h008
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [WORD_W-1:0]    rd_data,
    input  logic [WORD_W-1:0]    evt_set,
    output logic [NUM_LINES-1:0] irq_line
);
    localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_OFS);
    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_OFS);

    logic [WORD_W-1:0] flags_q, mask_q, active;

    evirq_regs #(
        .WORD_W(WORD_W), .ADDR_W(ADDR_W),
        .FLAG_OFS(FLAG_OFS), .MASK_OFS(MASK_OFS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .evt_set(evt_set),
        .flags_q(flags_q), .mask_q(mask_q)
    );

    assign active = flags_q & mask_q;

    evirq_lines #(.WORD_W(WORD_W), .NUM_LINES(NUM_LINES)) u_lines (
        .clk(clk), .rst_n(rst_n), .active(active), .irq_q(irq_line)
    );

    always_comb begin
        case (rd_addr)
            FLAG_A:  rd_data = flags_q;
            MASK_A:  rd_data = mask_q;
            default: rd_data = '0;
        endcase
    end

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (flags_q == '0 && mask_q == '0 && irq_line == '0));
endmodule

// File: tb/test_event_irq_fanout.sv
`timescale 1ns/1ps
module test_event_irq_fanout;
    localparam int NL = 13;
    localparam int SRC_BIT [NL] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};

    typedef struct packed {
        logic [31:0] set;
        logic [31:0] mask;
        logic [31:0] clr;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0000},
        '{32'h0FF8_0000, 32'hF0F0_F0F0, 32'h8000_0000},
        '{32'h0000_FFFF, 32'h0000_FFFF, 32'h0F00_0000},
        '{32'h7000_0000, 32'h5555_5555, 32'h0000_00FF},
        '{32'h0000_0000, 32'hFFF8_0000, 32'hFFFF_FFFF},
        '{32'hFFFF_FFFF, 32'h0A28_0000, 32'h0000_0001}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [9:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [9:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [31:0] evt_set = '0;
    logic [12:0] irq_line;

    int total = 0;
    int bad = 0;
    logic [31:0] m_flags = '0;
    logic [31:0] m_mask = '0;

    always #2.5 clk = ~clk;

    event_irq_fanout i_event_irq_fanout (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .evt_set(evt_set), .irq_line(irq_line)
    );

    function automatic logic [12:0] exp_lines(input logic [31:0] act);
        logic [12:0] r;
        for (int i = 0; i < NL; i++) r[i] = act[SRC_BIT[i]];
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [31:0] s);
        @(negedge clk);
        evt_set = s;
        @(negedge clk);
        evt_set = '0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic check_regs(input string req);
        logic [31:0] v;
        rd(10'h004, v); check({req, " flags"}, v, m_flags);
        rd(10'h008, v); check({req, " mask"}, v, m_mask);
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_regs("R1");
        check("R1 lines", {19'd0, irq_line}, 32'd0);
        rst_n = 1'b1;

        // Vector table: R2 R3 R4 R6 R9
        foreach (VECS[k]) begin
            wr(10'h008, VECS[k].mask); m_mask = VECS[k].mask;
            pulse(VECS[k].set);        m_flags |= VECS[k].set;
            wr(10'h004, VECS[k].clr);  m_flags &= ~VECS[k].clr;
            @(negedge clk);
            check_regs("R2/R3/R4");
            check("R6 lines", {19'd0, irq_line}, {19'd0, exp_lines(m_flags & m_mask)});
        end

        // R9: low bits latch but drive no line
        wr(10'h004, 32'hFFFF_FFFF); m_flags = '0;
        wr(10'h008, 32'hFFFF_FFFF); m_mask = 32'hFFFF_FFFF;
        pulse(32'h0007_FFFF); m_flags = 32'h0007_FFFF;
        @(negedge clk);
        check_regs("R9");
        check("R9 lines", {19'd0, irq_line}, 32'd0);

        // R7: one-edge lag after a mask write
        wr(10'h008, 32'd0); m_mask = '0;
        pulse(32'h0800_0000); m_flags |= 32'h0800_0000;
        @(negedge clk);
        check("R7 masked", {19'd0, irq_line}, 32'd0);
        wr(10'h008, 32'h0800_0000); m_mask = 32'h0800_0000;
        check("R7 before", {19'd0, irq_line}, 32'd0);
        @(negedge clk);
        check("R7 after", {19'd0, irq_line}, 32'd1);

        // R8: set wins over same-cycle clear; other cleared bit goes
        pulse(32'h0100_0000); m_flags |= 32'h0100_0000;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 10'h004; wr_data = 32'h0300_0000;
        evt_set = 32'h0200_0000;
        @(negedge clk);
        wr_en = 1'b0; evt_set = '0;
        m_flags = (m_flags & ~32'h0300_0000) | 32'h0200_0000;
        rd(10'h004, v);
        check("R8 set wins", v & 32'h0300_0000, 32'h0200_0000);

        // R5: other offsets read zero and writes there do nothing
        wr(10'h00C, 32'hFFFF_FFFF);
        wr(10'h000, 32'hFFFF_FFFF);
        check_regs("R5");
        rd(10'h00C, v); check("R5 rd other", v, 32'd0);
        rd(10'h3FC, v); check("R5 rd high", v, 32'd0);

        // R1: mid-run reset
        wr(10'h008, 32'hFFFF_FFFF); m_mask = 32'hFFFF_FFFF;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        m_flags = '0; m_mask = '0;
        check_regs("R1 mid");
        check("R1 mid lines", {19'd0, irq_line}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule